// File: doc/BRIEF.md
# GPIO Interrupt Channel Mux

This block takes a wide bank of GPIO pad inputs and routes a small fixed set of them onto eight interrupt channels for a downstream interrupt controller. Each channel has a byte-wide pad-number field that picks its source pad. The chosen pad then passes through a per-channel trigger conditioner. The conditioner can pass a level through unchanged or inverted. It can also turn a single edge (rising or falling) or any transition into a one-cycle high pulse. Because of this, the downstream controller only ever sees active-high levels or rising pulses.

Software configures the block through four 32-bit word registers on a plain address/write-strobe bus, and reads them back on the same bus. Pad numbers that name a pad which does not exist feed a constant low into the channel. A per-channel filter-select field is stored and can be read back, but it has no effect on the channel path in this block.

Top module: `gpio_irq_mux`

## Requirements
- R1: A synchronous active-high reset clears every register, so all reads return zero and every channel is in level-high mode on pad 0.
- R2: Byte offset 0x0 is the trigger word: bits [7:0] are single-edge enables, bits [15:8] are any-edge enables and bits [23:16] are invert flags, one bit per channel at bit position channel + group base. Bits [31:24] always read as zero. An access whose address bits [1:0] are not zero writes nothing and reads zero.
- R3: Channel c takes its pad number from the word at offset 0x4 (c < 4) or 0x8 (c >= 4), at bits [(c mod 4)*8 +: 8].
- R4: A pad number at or above NUM_PADS drives the channel's source low. Pad number NUM_PADS-1 is still routed.
- R5: In level mode (single-edge and any-edge enables both clear, invert clear), the channel output equals the selected pad one clock after the pad is sampled.
- R6: With the invert flag set in level mode, the output is the inverse of the selected pad, one clock later.
- R7: With the single-edge enable set and the invert flag clear, a 0-to-1 change of the pad gives a high output for exactly one cycle, and a 1-to-0 change gives none.
- R8: With the single-edge enable and the invert flag both set, a 1-to-0 change gives a one-cycle pulse, and a 0-to-1 change gives none.
- R9: The any-edge enable overrides the other two bits: every change of the pad gives a one-cycle pulse, and a steady pad gives a low output.
- R10: The filter word at offset 0xC (4 bits per channel at bit channel*4) stores and reads back all 32 bits and does not change any channel output.
- R11: A write becomes visible on the read data, and in the channel behaviour, only after the clock edge at which the write strobe is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational from the stored registers |
| pad_in | input | NUM_PADS | GPIO pad inputs |
| chan_irq | output | 8 | Conditioned interrupt line per channel |

## Verification
Read data follows bus_addr with no delay, and a written value appears on it right after the edge that samples the strobe. The bench therefore reads once before that edge, expecting the old value, and once after it, expecting the new value. A channel output is registered, so it reflects a pad value driven before edge N just after edge N. An edge pulse is high only in the cycle after that edge and is low again after edge N+1. The bench drives every input on the falling edge, steps one rising edge, and samples one nanosecond later. Pulse checks look at both the high cycle and the cycle that follows.

// File: rtl/gpio_irq_mux_pkg.sv
package gpio_irq_mux_pkg;
    localparam int NUM_CH    = 8;
    localparam int SEL_W     = 8;
    localparam int FILT_W    = 4;
    localparam int DATA_W    = 32;
    localparam int TRIG_W    = 3 * NUM_CH;
    localparam int SEL_ALL_W = NUM_CH * SEL_W;
    localparam int PAD_SPACE = 1 << SEL_W;

    localparam logic [1:0] W_TRIG   = 2'd0;
    localparam logic [1:0] W_SEL_LO = 2'd1;
    localparam logic [1:0] W_SEL_HI = 2'd2;
    localparam logic [1:0] W_FILT   = 2'd3;

    typedef struct packed {
        logic [TRIG_W-1:0]    trig;
        logic [SEL_ALL_W-1:0] sel;
        logic [DATA_W-1:0]    filt;
    } regs_t;

    typedef struct packed {
        logic [NUM_CH-1:0] prev;
        logic [NUM_CH-1:0] irq;
    } cond_t;
endpackage

// File: rtl/gim_regs.sv
module gim_regs
    import gpio_irq_mux_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [3:0]           bus_addr,
    input  logic                 bus_we,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [NUM_CH-1:0]    edge_en,
    output logic [NUM_CH-1:0]    both_en,
    output logic [NUM_CH-1:0]    low_en,
    output logic [SEL_ALL_W-1:0] sel_flat
);
    localparam int HALF_SEL = SEL_ALL_W / 2;

    regs_t regs_d, regs_q;
    logic  aligned;

    assign aligned = (bus_addr[1:0] == 2'b00);

    always_comb begin
        regs_d = regs_q;
        if (bus_we && aligned) begin
            case (bus_addr[3:2])
                W_TRIG:   regs_d.trig = bus_wdata[TRIG_W-1:0];
                W_SEL_LO: regs_d.sel[HALF_SEL-1:0] = bus_wdata[HALF_SEL-1:0];
                W_SEL_HI: regs_d.sel[SEL_ALL_W-1:HALF_SEL] = bus_wdata[HALF_SEL-1:0];
                default:  regs_d.filt = bus_wdata;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q <= '0;
        else     regs_q <= regs_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            case (bus_addr[3:2])
                W_TRIG:   bus_rdata = DATA_W'(regs_q.trig);
                W_SEL_LO: bus_rdata = DATA_W'(regs_q.sel[HALF_SEL-1:0]);
                W_SEL_HI: bus_rdata = DATA_W'(regs_q.sel[SEL_ALL_W-1:HALF_SEL]);
                default:  bus_rdata = regs_q.filt;
            endcase
        end
    end

    assign edge_en  = regs_q.trig[NUM_CH-1:0];
    assign both_en  = regs_q.trig[2*NUM_CH-1:NUM_CH];
    assign low_en   = regs_q.trig[3*NUM_CH-1:2*NUM_CH];
    assign sel_flat = regs_q.sel;
endmodule

// File: rtl/gim_padmux.sv
module gim_padmux
    import gpio_irq_mux_pkg::*;
#(
    parameter int NUM_PADS = 134
) (
    input  logic [NUM_PADS-1:0]  pad_in,
    input  logic [SEL_ALL_W-1:0] sel_flat,
    output logic [NUM_CH-1:0]    sel_pad
);
    logic [PAD_SPACE-1:0] pad_ext;

    // Pads past NUM_PADS are zero-filled, so an out-of-range number yields 0
    assign pad_ext = PAD_SPACE'(pad_in);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_mux
        logic [SEL_W-1:0] num;
        assign num        = sel_flat[c*SEL_W +: SEL_W];
        assign sel_pad[c] = pad_ext[num];
    end
endmodule

// File: rtl/gim_trigger.sv
module gim_trigger
    import gpio_irq_mux_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] sel_pad,
    input  logic [NUM_CH-1:0] edge_en,
    input  logic [NUM_CH-1:0] both_en,
    input  logic [NUM_CH-1:0] low_en,
    output logic [NUM_CH-1:0] chan_irq
);
    cond_t st_d, st_q;

    always_comb begin
        st_d.prev = sel_pad;
        for (int c = 0; c < NUM_CH; c++) begin
            logic cur_pol, old_pol;
            cur_pol = sel_pad[c] ^ low_en[c];
            old_pol = st_q.prev[c] ^ low_en[c];
            if (both_en[c])      st_d.irq[c] = sel_pad[c] ^ st_q.prev[c];
            else if (edge_en[c]) st_d.irq[c] = cur_pol & ~old_pol;
            else                 st_d.irq[c] = cur_pol;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign chan_irq = st_q.irq;
endmodule

// File: rtl/gpio_irq_mux.sv
module gpio_irq_mux
    import gpio_irq_mux_pkg::*;
#(
    parameter int NUM_PADS = 134
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [3:0]          bus_addr,
    input  logic                bus_we,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PADS-1:0] pad_in,
    output logic [7:0]          chan_irq
);
    logic [NUM_CH-1:0]    edge_en, both_en, low_en, sel_pad;
    logic [SEL_ALL_W-1:0] sel_flat;

    gim_regs regs_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .edge_en(edge_en),
        .both_en(both_en), .low_en(low_en), .sel_flat(sel_flat)
    );

    gim_padmux #(.NUM_PADS(NUM_PADS)) mux_i (
        .pad_in(pad_in), .sel_flat(sel_flat), .sel_pad(sel_pad)
    );

    gim_trigger trig_i (
        .clk(clk), .rst(rst), .sel_pad(sel_pad), .edge_en(edge_en),
        .both_en(both_en), .low_en(low_en), .chan_irq(chan_irq)
    );
endmodule

// File: rtl/gpio_irq_mux_chk.sv
module gpio_irq_mux_chk
    import gpio_irq_mux_pkg::*;
#(
    parameter int NUM_PADS = 134
) (
    input logic                 clk,
    input logic                 rst,
    input logic [3:0]           bus_addr,
    input logic [31:0]          bus_rdata,
    input logic [NUM_CH-1:0]    edge_en,
    input logic [NUM_CH-1:0]    both_en,
    input logic [NUM_CH-1:0]    low_en,
    input logic [SEL_ALL_W-1:0] sel_flat,
    input logic [NUM_CH-1:0]    sel_pad,
    input logic [7:0]           chan_irq
);
    logic armed_q;

    always_ff @(posedge clk) armed_q <= !rst;

    p_trig_top_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 4'h0) |-> (bus_rdata[31:24] == 8'h00));

    p_misaligned_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[1:0] != 2'b00) |-> (bus_rdata == 32'h0));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        p_oor_r4: assert property (@(posedge clk) disable iff (rst)
            (int'(sel_flat[c*SEL_W +: SEL_W]) >= NUM_PADS) |-> !sel_pad[c]);

        // R5 and R6: level path, with or without inversion
        p_level_r5: assert property (@(posedge clk) disable iff (rst)
            (!edge_en[c] && !both_en[c]) |=> (chan_irq[c] == ($past(sel_pad[c]) ^ $past(low_en[c]))));

        p_any_edge_r9: assert property (@(posedge clk) disable iff (rst)
            (armed_q && both_en[c] && (sel_pad[c] != $past(sel_pad[c]))) |=> chan_irq[c]);

        // R7 and R8: no pulse while the selected pad holds still
        p_edge_quiet_r7: assert property (@(posedge clk) disable iff (rst)
            (armed_q && (edge_en[c] || both_en[c]) && (sel_pad[c] == $past(sel_pad[c]))) |=> !chan_irq[c]);
    end
endmodule

bind gpio_irq_mux gpio_irq_mux_chk #(.NUM_PADS(NUM_PADS)) chk_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .edge_en(edge_en), .both_en(both_en), .low_en(low_en),
    .sel_flat(sel_flat), .sel_pad(sel_pad), .chan_irq(chan_irq)
);

// File: tb/gpio_irq_mux_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_mux_tb_top;
    localparam int NP = 134;

    logic          clk = 1'b0;
    logic          rst;
    logic [3:0]    bus_addr;
    logic          bus_we;
    logic [31:0]   bus_wdata;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pad_in;
    logic [7:0]    chan_irq;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 0;

    always #2 clk = ~clk;

    gpio_irq_mux #(.NUM_PADS(NP)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .chan_irq(chan_irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(bus_rdata == exp, tag, bus_rdata, exp);
    endtask

    task automatic irq_bit_chk(input int c, input logic exp, input string tag);
        chk(chan_irq[c] == exp, tag, 32'(chan_irq[c]), 32'(exp));
    endtask

    task automatic t_reset();
        rst = 1'b1; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; pad_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        step();
        chk(chan_irq == 8'h00, "R1 irq after reset", 32'(chan_irq), 0);
        for (int w = 0; w < 4; w++) rd_chk(4'(w*4), 32'h0, "R1 register after reset");
    endtask

    task automatic t_regmap();
        wr(4'h0, 32'hFFFF_FFFF);
        rd_chk(4'h0, 32'h00FF_FFFF, "R2 trigger word upper bits zero");
        wr(4'h4, 32'h0403_0201);
        wr(4'h8, 32'h0807_0605);
        rd_chk(4'h4, 32'h0403_0201, "R2 select low word");
        rd_chk(4'h8, 32'h0807_0605, "R2 select high word");
        wr(4'h5, 32'hDEAD_BEEF);
        rd_chk(4'h4, 32'h0403_0201, "R2 misaligned write ignored");
        rd_chk(4'h5, 32'h0, "R2 misaligned read zero");
        wr(4'h0, 32'h0); wr(4'h4, 32'h0); wr(4'h8, 32'h0);
    endtask

    task automatic t_write_timing();
        @(negedge clk);
        bus_addr = 4'hC; bus_wdata = 32'h1357_9BDF; bus_we = 1'b1;
        #1;
        chk(bus_rdata == 32'h0, "R11 old value before edge", bus_rdata, 0);
        step();
        chk(bus_rdata == 32'h1357_9BDF, "R11 new value after edge", bus_rdata, 32'h1357_9BDF);
        @(negedge clk); bus_we = 1'b0;
        wr(4'hC, 32'h0);
    endtask

    task automatic t_select();
        logic [7:0]  p [8];
        logic [31:0] lo, hi;
        for (int c = 0; c < 8; c++) p[c] = 8'(10 + c*17);
        lo = {p[3], p[2], p[1], p[0]};
        hi = {p[7], p[6], p[5], p[4]};
        wr(4'h4, lo); wr(4'h8, hi);
        for (int c = 0; c < 8; c++) begin
            @(negedge clk); pad_in = '0; pad_in[p[c]] = 1'b1;
            step();
            chk(chan_irq == 8'(1 << c), "R3 channel follows its field", 32'(chan_irq), 32'(1 << c));
        end
        wr(4'h8, 32'h8500_0000);
        @(negedge clk); pad_in = '0; pad_in[133] = 1'b1;
        step();
        chk(chan_irq == 8'h80, "R4 last valid pad routed", 32'(chan_irq), 32'h80);
        @(negedge clk); pad_in = '0;
        wr(4'h4, 32'h0); wr(4'h8, 32'h0);
    endtask

    task automatic t_oor();
        @(negedge clk); pad_in = '1;
        wr(4'h4, 32'h0000_0086);
        step();
        irq_bit_chk(0, 1'b0, "R4 pad number 134 reads low");
        wr(4'h4, 32'h0000_00FF);
        step();
        irq_bit_chk(0, 1'b0, "R4 pad number 255 reads low");
        wr(4'h0, 32'h0001_0000);
        step();
        irq_bit_chk(0, 1'b1, "R4 inverted out-of-range source is high");
        wr(4'h0, 32'h0); wr(4'h4, 32'h0);
        @(negedge clk); pad_in = '0;
    endtask

    task automatic t_level();
        wr(4'h4, 32'h0000_2A00);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); pad_in[42] = 1'(i % 2);
            step();
            irq_bit_chk(1, 1'(i % 2), "R5 level follows pad");
        end
        wr(4'h0, 32'h0002_0000);
        @(negedge clk); pad_in[42] = 1'b0;
        step();
        irq_bit_chk(1, 1'b1, "R6 inverted level, pad low");
        @(negedge clk); pad_in[42] = 1'b1;
        step();
        irq_bit_chk(1, 1'b0, "R6 inverted level, pad high");
        wr(4'h0, 32'h0);
        @(negedge clk); pad_in[42] = 1'b0;
    endtask

    task automatic t_rise();
        wr(4'h4, 32'h0000_0500);
        wr(4'h0, 32'h0000_0002);
        step(); step();
        irq_bit_chk(1, 1'b0, "R7 idle low");
        @(negedge clk); pad_in[5] = 1'b1;
        step();
        irq_bit_chk(1, 1'b1, "R7 rising pulse");
        step();
        irq_bit_chk(1, 1'b0, "R7 pulse lasts one cycle");
        @(negedge clk); pad_in[5] = 1'b0;
        step();
        irq_bit_chk(1, 1'b0, "R7 falling ignored");
    endtask

    task automatic t_fall();
        wr(4'h0, 32'h0002_0002);
        step();
        irq_bit_chk(1, 1'b0, "R8 idle low");
        @(negedge clk); pad_in[5] = 1'b1;
        step();
        irq_bit_chk(1, 1'b0, "R8 rising ignored");
        @(negedge clk); pad_in[5] = 1'b0;
        step();
        irq_bit_chk(1, 1'b1, "R8 falling pulse");
        step();
        irq_bit_chk(1, 1'b0, "R8 pulse lasts one cycle");
    endtask

    task automatic t_both();
        wr(4'h0, 32'h0002_0202);
        step();
        irq_bit_chk(1, 1'b0, "R9 steady pad low");
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); pad_in[5] = ~pad_in[5];
            step();
            irq_bit_chk(1, 1'b1, "R9 pulse on each change");
        end
        step();
        irq_bit_chk(1, 1'b0, "R9 low once pad holds");
        wr(4'h0, 32'h0);
        @(negedge clk); pad_in = '0;
    endtask

    task automatic t_filter();
        wr(4'h4, 32'h0000_0007);
        wr(4'hC, 32'hFFFF_FFFF);
        rd_chk(4'hC, 32'hFFFF_FFFF, "R10 filter word reads back");
        @(negedge clk); pad_in[7] = 1'b1;
        step();
        irq_bit_chk(0, 1'b1, "R10 filter has no effect, pad high");
        @(negedge clk); pad_in[7] = 1'b0;
        step();
        irq_bit_chk(0, 1'b0, "R10 filter has no effect, pad low");
    endtask

    initial begin
        t_reset();
        t_regmap();
        t_write_timing();
        t_select();
        t_oor();
        t_level();
        t_rise();
        t_fall();
        t_both();
        t_filter();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule